// File: doc/BRIEF.md
# USB Frame Bus-Time Admission Checker

This block sits beside a USB host transaction engine and decides, once per clock, whether a queued full-speed or low-speed transaction may still begin inside the current 1 ms frame. Two transaction slots feed it. Slot A is bit 0 of every per-slot vector and slot B is bit 1. Each slot presents a payload length and a low-speed flag. The block turns these into a worst-case bus cost in full-speed bit times, using only shifts and adds. It registers that cost, then compares it with the time still left in the frame. The time left comes from the frame countdown value with a fixed end-of-frame guard band removed.

Software or a sequencer arms a slot with a one-cycle pulse. While no slot is running, the block offers slot A first. If A is not pending, is being aborted, or does not fit, it offers slot B. It starts at most one slot per decision and pulses that slot's start output for exactly one cycle. It then holds the slot busy until a done pulse arrives. A pending slot with its abort input high is dropped without starting, and its length is flagged void. A low-speed slot whose length exceeds 8 bytes is never admitted and is flagged as rejected.

Top module: `usb_frame_admit`

## Requirements
- R1: Remaining time equals max(frame_cnt_i*64 - 128, 0) in full-speed bit times. The subtraction saturates, so with frame_cnt_i of 2 or less nothing ever starts.
- R2: A full-speed slot (low_i bit 0) costs 114 + 8*len + len + floor(len/2).
- R3: A low-speed slot (low_i bit 1) costs 804 + 64*len + 16*len.
- R4: A low-speed slot with len above 8 never starts. While it is pending, its rej_o bit is 1.
- R5: With both slots pending and fitting, slot A starts and slot B does not. At most one slot is busy at any time.
- R6: A pending slot starts only when the remaining time is greater than or equal to its cost. Its start_o bit is then high for one cycle, its pending state clears, and its busy_o bit is 1 from the next cycle until its done_i pulse.
- R7: While any busy_o bit is 1, no start_o bit rises, even for a pending slot that fits.
- R8: An idle decision on a pending slot with abort_i high drops that slot without a start and sets its void_o bit. The same decision still offers slot B. void_o clears on the slot's next arm pulse.
- R9: The cost is registered. A change of len_i or low_i affects admission only from the clock edge after the change.
- R10: A zero-length transaction costs only its base constant: 114 at full speed, 804 at low speed.
- R11: After reset, start_o, busy_o, void_o and rej_o are all 0.
- R12: Slot B is offered and may start when slot A is not pending or does not fit, and slot A then stays pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_cnt_i | input | 8 | Frame countdown value, in units of 64 full-speed bit times |
| arm_i | input | 2 | Per-slot arm pulse (bit 0 = A, bit 1 = B) |
| abort_i | input | 2 | Per-slot abort level; a pending slot is dropped at the next idle decision |
| low_i | input | 2 | Per-slot speed, 1 = low speed |
| len_i | input | 16 | Per-slot payload length in bytes, slot A in bits 7:0, slot B in bits 15:8 |
| done_i | input | 2 | Per-slot completion pulse, clears busy |
| start_o | output | 2 | Per-slot one-cycle start strobe |
| busy_o | output | 2 | Per-slot transaction in progress |
| void_o | output | 2 | Per-slot length-invalid flag after an abort |
| rej_o | output | 2 | Pending low-speed slot whose length is over the limit |

## Verification
The hardest case to reach is a cost that exactly equals the remaining time. The remaining time moves in steps of 64, so only a few lengths produce a cost on that grid. A full-speed length of 116 gives 1216, which equals the time left at a countdown of 21 and exceeds the time left at 20. The stimulus steps the countdown across that edge while the slot stays pending. A second hard case is an abort and a start in the same decision. It is reached by holding abort on slot A while both slots are armed in the same cycle, so that A is dropped and B starts in that one decision.

// File: rtl/adm_pkg.sv
package adm_pkg;
  localparam int unsigned CNT_W   = 8;
  localparam int unsigned LEN_W   = 8;
  localparam int unsigned NSLOT   = 2;
  localparam int unsigned TICK_SH = 6;
  localparam int unsigned GUARD   = 128;
  localparam int unsigned FS_BASE = 114;
  localparam int unsigned LS_BASE = 804;
  localparam int unsigned LS_MAX  = 8;
endpackage

// File: rtl/adm_remain.sv
module adm_remain #(
  parameter int unsigned CNT_W   = adm_pkg::CNT_W,
  parameter int unsigned TICK_SH = adm_pkg::TICK_SH,
  parameter int unsigned GUARD   = adm_pkg::GUARD,
  localparam int unsigned REM_W  = CNT_W + TICK_SH
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic [REM_W-1:0] rem_o
);
  logic [REM_W-1:0] full;

  always_comb begin
    full = {cnt_i, {TICK_SH{1'b0}}};
    // saturate: below the guard band nothing may be admitted
    rem_o = (full > REM_W'(GUARD)) ? full - REM_W'(GUARD) : '0;
  end
endmodule

// File: rtl/adm_cost.sv
module adm_cost #(
  parameter int unsigned LEN_W   = adm_pkg::LEN_W,
  parameter int unsigned FS_BASE = adm_pkg::FS_BASE,
  parameter int unsigned LS_BASE = adm_pkg::LS_BASE,
  parameter int unsigned LS_MAX  = adm_pkg::LS_MAX,
  localparam int unsigned COST_W = LEN_W + 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              low_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [COST_W-1:0] cost_o,
  output logic              valid_o
);
  logic [COST_W-1:0] ext, fs_cost, ls_cost;
  logic              ok;

  always_comb begin
    ext     = COST_W'(len_i);
    fs_cost = COST_W'(FS_BASE) + (ext << 3) + ext + (ext >> 1);
    ls_cost = COST_W'(LS_BASE) + (ext << 6) + (ext << 4);
    ok      = !low_i || (len_i <= LEN_W'(LS_MAX));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cost_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      cost_o  <= low_i ? ls_cost : fs_cost;
      valid_o <= ok;
    end
  end

  // R4: oversize low-speed length is marked unusable
  a_r4_ls_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_i && (len_i > LEN_W'(LS_MAX))) |=> !valid_o);
  // R2: any full-speed cost is at least its base
  a_r2_fs_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !low_i |=> (cost_o >= COST_W'(FS_BASE)));
  // R3: any low-speed cost is at least its base
  a_r3_ls_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_i |=> (cost_o >= COST_W'(LS_BASE)));
endmodule

// File: rtl/adm_arbiter.sv
module adm_arbiter #(
  parameter int unsigned NSLOT  = adm_pkg::NSLOT,
  parameter int unsigned REM_W  = 14,
  parameter int unsigned COST_W = 15
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [REM_W-1:0]             rem_i,
  input  logic [NSLOT-1:0][COST_W-1:0] cost_i,
  input  logic [NSLOT-1:0]             valid_i,
  input  logic [NSLOT-1:0]             arm_i,
  input  logic [NSLOT-1:0]             abort_i,
  input  logic [NSLOT-1:0]             done_i,
  output logic [NSLOT-1:0]             start_o,
  output logic [NSLOT-1:0]             busy_o,
  output logic [NSLOT-1:0]             void_o,
  output logic [NSLOT-1:0]             rej_o
);
  logic [NSLOT-1:0] pend_q, busy_q, void_q;
  logic [NSLOT-1:0] go, clr, fit;
  logic             idle, taken;

  // lowest index wins; aborted slots are dropped and the scan continues
  always_comb begin
    idle  = ~|busy_q;
    taken = 1'b0;
    go    = '0;
    clr   = '0;
    for (int i = 0; i < NSLOT; i++) begin
      fit[i] = valid_i[i] && (COST_W'(rem_i) >= cost_i[i]);
      if (idle && pend_q[i]) begin
        if (abort_i[i]) clr[i] = 1'b1;
        else if (fit[i] && !taken) begin
          go[i] = 1'b1;
          taken = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      busy_q <= '0;
      void_q <= '0;
    end else begin
      pend_q <= (pend_q & ~go & ~clr) | arm_i;
      busy_q <= (busy_q & ~done_i) | go;
      void_q <= (void_q & ~arm_i) | clr;
    end
  end

  assign start_o = go;
  assign busy_o  = busy_q;
  assign void_o  = void_q;
  assign rej_o   = pend_q & ~valid_i;

  // R5: never two transactions in flight
  a_r5_one_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(busy_q));

  for (genvar g = 0; g < NSLOT; g++) begin : g_chk
    // R6: a start retires the pending request and marks the slot busy
    a_r6_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_o[g] && !arm_i[g]) |=> (busy_q[g] && !pend_q[g]));
    // R8: a dropped slot is flagged void and not started
    a_r8_abort_void: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q[g] && abort_i[g] && idle && !arm_i[g]) |=> (void_q[g] && !pend_q[g] && !busy_q[g]));
  end
endmodule

// File: rtl/usb_frame_admit.sv
module usb_frame_admit #(
  parameter int unsigned CNT_W   = adm_pkg::CNT_W,
  parameter int unsigned LEN_W   = adm_pkg::LEN_W,
  parameter int unsigned NSLOT   = adm_pkg::NSLOT,
  parameter int unsigned TICK_SH = adm_pkg::TICK_SH,
  parameter int unsigned GUARD   = adm_pkg::GUARD,
  parameter int unsigned FS_BASE = adm_pkg::FS_BASE,
  parameter int unsigned LS_BASE = adm_pkg::LS_BASE,
  parameter int unsigned LS_MAX  = adm_pkg::LS_MAX
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [CNT_W-1:0]       frame_cnt_i,
  input  logic [NSLOT-1:0]       arm_i,
  input  logic [NSLOT-1:0]       abort_i,
  input  logic [NSLOT-1:0]       low_i,
  input  logic [NSLOT*LEN_W-1:0] len_i,
  input  logic [NSLOT-1:0]       done_i,
  output logic [NSLOT-1:0]       start_o,
  output logic [NSLOT-1:0]       busy_o,
  output logic [NSLOT-1:0]       void_o,
  output logic [NSLOT-1:0]       rej_o
);
  localparam int unsigned REM_W  = CNT_W + TICK_SH;
  localparam int unsigned COST_W = LEN_W + 7;

  logic [REM_W-1:0]             rem;
  logic [NSLOT-1:0][COST_W-1:0] cost;
  logic [NSLOT-1:0]             valid;

  adm_remain #(.CNT_W(CNT_W), .TICK_SH(TICK_SH), .GUARD(GUARD)) u_rem (
    .cnt_i (frame_cnt_i),
    .rem_o (rem)
  );

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    adm_cost #(.LEN_W(LEN_W), .FS_BASE(FS_BASE), .LS_BASE(LS_BASE), .LS_MAX(LS_MAX)) u_cost (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .low_i   (low_i[g]),
      .len_i   (len_i[g*LEN_W +: LEN_W]),
      .cost_o  (cost[g]),
      .valid_o (valid[g])
    );
  end

  adm_arbiter #(.NSLOT(NSLOT), .REM_W(REM_W), .COST_W(COST_W)) u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rem_i   (rem),
    .cost_i  (cost),
    .valid_i (valid),
    .arm_i   (arm_i),
    .abort_i (abort_i),
    .done_i  (done_i),
    .start_o (start_o),
    .busy_o  (busy_o),
    .void_o  (void_o),
    .rej_o   (rej_o)
  );

  // R1: inside the guard band nothing is admitted
  a_r1_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_cnt_i <= CNT_W'(GUARD >> TICK_SH)) |-> (start_o == '0));
endmodule

// File: tb/sim_usb_frame_admit.sv
module sim_usb_frame_admit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  frame_cnt_i = '0;
  logic [1:0]  arm_i = '0, abort_i = '0, low_i = '0, done_i = '0;
  logic [15:0] len_i = '0;
  logic [1:0]  start_o, busy_o, void_o, rej_o;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;

  usb_frame_admit u0 (.*);

  function automatic int fs_cost(int len); return 114 + len*8 + len + len/2; endfunction
  function automatic int ls_cost(int len); return 804 + len*80; endfunction
  function automatic int rem_of(int cnt); return (cnt*64 > 128) ? cnt*64 - 128 : 0; endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; arm_i = '0; abort_i = '0; low_i = '0; done_i = '0; len_i = '0; frame_cnt_i = '0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  // set slot parameters, let the cost register load, then pulse arm
  task automatic prep(int cnt, int la, bit sa, int lb, bit sb);
    frame_cnt_i = 8'(cnt); len_i = {8'(lb), 8'(la)}; low_i = {sb, sa};
    @(negedge clk_i);
  endtask

  task automatic arm(logic [1:0] m);
    arm_i = m;
    @(negedge clk_i);
    arm_i = '0;
    #1;
  endtask

  task automatic t_reset();
    do_reset(); #1;
    chk("R11 start", int'(start_o), 0);
    chk("R11 busy", int'(busy_o), 0);
    chk("R11 void", int'(void_o), 0);
    chk("R11 rej", int'(rej_o), 0);
  endtask

  task automatic t_fs_exact();
    do_reset();
    prep(20, 116, 0, 0, 0);
    arm(2'b01);
    chk("R2 len116 cnt20", int'(start_o), (rem_of(20) >= fs_cost(116)) ? 1 : 0);
    frame_cnt_i = 8'd21; #1;
    chk("R6 exact fit cnt21", int'(start_o), (rem_of(21) >= fs_cost(116)) ? 1 : 0);
    @(negedge clk_i); #1;
    chk("R6 strobe one cycle", int'(start_o), 0);
    chk("R6 busy set", int'(busy_o), 1);
    done_i = 2'b01; @(negedge clk_i); done_i = '0; #1;
    chk("R6 done clears busy", int'(busy_o), 0);
  endtask

  task automatic t_fs_64();
    do_reset();
    prep(13, 64, 0, 0, 0);
    arm(2'b01);
    chk("R2 len64 cnt13", int'(start_o), (rem_of(13) >= fs_cost(64)) ? 1 : 0);
    frame_cnt_i = 8'd14; #1;
    chk("R2 len64 cnt14", int'(start_o), (rem_of(14) >= fs_cost(64)) ? 1 : 0);
  endtask

  task automatic t_ls();
    do_reset();
    prep(24, 8, 1, 0, 0);
    arm(2'b01);
    chk("R3 ls len8 cnt24", int'(start_o), (rem_of(24) >= ls_cost(8)) ? 1 : 0);
    frame_cnt_i = 8'd25; #1;
    chk("R3 ls len8 cnt25", int'(start_o), (rem_of(25) >= ls_cost(8)) ? 1 : 0);
  endtask

  task automatic t_ls_reject();
    do_reset();
    prep(255, 9, 1, 0, 0);
    arm(2'b01);
    chk("R4 ls len9 no start", int'(start_o), 0);
    chk("R4 rej flag", int'(rej_o), 1);
    @(negedge clk_i); #1;
    chk("R4 still not busy", int'(busy_o), 0);
  endtask

  task automatic t_zero();
    do_reset();
    prep(3, 0, 0, 0, 0);
    arm(2'b10);
    chk("R10 fs len0 cnt3", int'(start_o), 0);
    frame_cnt_i = 8'd4; #1;
    chk("R10 fs len0 cnt4 slot B", int'(start_o), 2);
    do_reset();
    prep(14, 0, 0, 0, 1);
    arm(2'b10);
    chk("R10 ls len0 cnt14", int'(start_o), 0);
    frame_cnt_i = 8'd15; #1;
    chk("R10 ls len0 cnt15", int'(start_o), 2);
  endtask

  task automatic t_sat();
    do_reset();
    prep(1, 0, 0, 0, 0);
    arm(2'b01);
    chk("R1 cnt1 no start", int'(start_o), 0);
    frame_cnt_i = 8'd0; #1;
    chk("R1 cnt0 no start", int'(start_o), 0);
    frame_cnt_i = 8'd2; #1;
    chk("R1 cnt2 no start", int'(start_o), 0);
  endtask

  task automatic t_priority();
    do_reset();
    prep(100, 10, 0, 10, 0);
    arm(2'b11);
    chk("R5 A before B", int'(start_o), 1);
    @(negedge clk_i); #1;
    chk("R7 B held while A busy", int'(start_o), 0);
    chk("R5 only A busy", int'(busy_o), 1);
    done_i = 2'b01; @(negedge clk_i); done_i = '0; #1;
    chk("R5 B after A done", int'(start_o), 2);
  endtask

  task automatic t_skip();
    do_reset();
    prep(20, 200, 0, 0, 0);
    arm(2'b11);
    chk("R12 B when A too big", int'(start_o), 2);
    @(negedge clk_i); #1;
    chk("R12 B busy", int'(busy_o), 2);
    done_i = 2'b10; @(negedge clk_i); done_i = '0;
    frame_cnt_i = 8'd50; #1;
    chk("R12 A stayed pending", int'(start_o), 1);
  endtask

  task automatic t_abort();
    do_reset();
    prep(100, 10, 0, 10, 0);
    abort_i = 2'b01;
    arm(2'b11);
    chk("R8 A dropped B starts", int'(start_o), 2);
    @(negedge clk_i); #1;
    chk("R8 void A", int'(void_o), 1);
    chk("R8 B busy", int'(busy_o), 2);
    abort_i = '0;
    arm(2'b01);
    chk("R8 void cleared by arm", int'(void_o), 0);
  endtask

  task automatic t_reg();
    do_reset();
    prep(20, 200, 0, 0, 0);
    arm(2'b01);
    chk("R9 big len waits", int'(start_o), 0);
    len_i[7:0] = 8'd0; #1;
    chk("R9 no effect before edge", int'(start_o), 0);
    @(negedge clk_i); #1;
    chk("R9 effect after edge", int'(start_o), 1);
  endtask

  initial begin
    t_reset();
    t_fs_exact();
    t_fs_64();
    t_ls();
    t_ls_reject();
    t_zero();
    t_sat();
    t_priority();
    t_skip();
    t_abort();
    t_reg();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule